// File: doc/BRIEF.md
# Two-Level Overcurrent Fault Timer

This block decides when a multiphase buck regulator must shut down for overcurrent. A digitized current-limit sense code is compared each cycle against two limits. The lower limit (the 100 % level) trips only after it has been exceeded without a break for a programmable number of cycles. The upper limit (the 150 % level) trips on the next clock edge. When a trip occurs, a fault is latched and the drivers are told to switch off. The fault stays latched until the block is disabled or the supply-good flag drops.

In the light-load power states the regulator runs fewer phases, so both limits are divided by the phase count configured for full-power mode. No divider is used. Instead, the sense code multiplied by the phase count is compared against the undivided limit, which gives an exact result for one to four phases.

Protection is not armed at power-up. It becomes armed once the output-voltage code or the DAC code rises above its own arming level. Until then, a short on the output cannot raise a false fault.

Top module: `ocp_fault_timer`

## Requirements
- R1: In the full-power state (pstate code 0), a sense code strictly above LIM_SLOW (default 400) that is sampled on DLY_CYC consecutive edges (default 50) sets fault_latched on the DLY_CYC-th of those edges. One edge fewer leaves it clear.
- R2: Any edge that samples a sense code not above the slow limit restarts the delay count from zero.
- R3: Once armed, a sense code strictly above LIM_FAST (default 600) sets fault_latched on the very edge that samples it.
- R4: In pstate codes 1, 2 and 3, a level is exceeded when sense_code multiplied by the phase count is strictly above that level's limit. In code 0, the sense code alone is compared.
- R5: A full_phases code of 0 is treated as one phase, and codes above MAX_PH (default 4) are treated as MAX_PH.
- R6: Arming happens on the edge that sees vout_code above VOUT_ARM (default 50) or dac_code above DAC_ARM (default 60). That edge itself cannot trip. No fault can arise before arming, whatever the sense code.
- R7: A latched fault stays set while en and supply_ok are both high, even after the current falls. An edge that samples en low or supply_ok low clears the fault and disarms the block.
- R8: drv_off is high on every cycle in which the fault is latched or the block was disabled on the previous edge, and low otherwise.
- R9: During and after reset, fault_latched is 0 and drv_off is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Regulator enable |
| supply_ok | input | 1 | Controller supply above its lockout level |
| sense_code | input | SW (10) | Digitized current-limit sense value |
| full_phases | input | 3 | Number of phases in the full-power state |
| pstate | input | 2 | Power state: 0 is full power, 1 to 3 are reduced |
| vout_code | input | VW (8) | Digitized output voltage |
| dac_code | input | VW (8) | Present DAC code |
| fault_latched | output | 1 | Latched overcurrent fault |
| drv_off | output | 1 | Request to turn the phase drivers off |

## Verification
Every result is due on a known edge. Arming takes effect on the edge after the arming code is seen. A fast trip shows on the first edge that samples the high current. A slow trip shows on the DLY_CYC-th consecutive sampling edge. A clear shows on the edge that samples en or supply_ok low. The bench drives inputs one time unit after a rising edge and reads the outputs at that same point. Each check is therefore taken after exactly the number of edges its requirement names. Around every timed trip, a check one edge earlier confirms the output has not yet changed.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        PST_FULL   = 2'd0,
        PST_LIGHT1 = 2'd1,
        PST_LIGHT2 = 2'd2,
        PST_LIGHT3 = 2'd3
    } pstate_e;

    typedef struct packed {
        logic fault;
        logic drv_off;
    } ocp_state_t;

    localparam ocp_state_t OCP_RESET = '{fault: 1'b0, drv_off: 1'b1};

endpackage

// File: rtl/ocp_lvl_cmp.sv
module ocp_lvl_cmp #(
    parameter int SW     = 10,
    parameter int LIMIT  = 400,
    parameter int MAX_PH = 4
) (
    input  logic [SW-1:0] sense,
    input  logic [2:0]    nph_raw,
    input  logic          reduced,
    output logic          over
);
    localparam int PW = SW + 3;

    logic [2:0]    nph_eff;
    logic [PW-1:0] prod;

    always_comb begin
        if (nph_raw == 3'd0)
            nph_eff = 3'd1;
        else if (int'(nph_raw) > MAX_PH)
            nph_eff = 3'(MAX_PH);
        else
            nph_eff = nph_raw;
        prod = PW'(sense) * PW'(nph_eff);
        if (reduced)
            over = prod > PW'(LIMIT);
        else
            over = PW'(sense) > PW'(LIMIT);
    end

endmodule

// File: rtl/ocp_delay_cnt.sv
module ocp_delay_cnt #(
    parameter int DLY = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(DLY + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && (cnt_q == CW'(DLY - 1));
        if (!run)
            cnt_d = '0;
        else if (expire)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/ocp_arm.sv
module ocp_arm #(
    parameter int VW       = 8,
    parameter int VOUT_ARM = 50,
    parameter int DAC_ARM  = 60
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [VW-1:0] vout,
    input  logic [VW-1:0] dac,
    output logic          armed_q
);
    logic armed_d;

    always_comb begin
        if (clr)
            armed_d = 1'b0;
        else
            armed_d = armed_q || (vout > VW'(VOUT_ARM)) || (dac > VW'(DAC_ARM));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

endmodule

// File: rtl/ocp_fault_timer.sv
module ocp_fault_timer
    import ocp_pkg::*;
#(
    parameter int SW       = 10,
    parameter int VW       = 8,
    parameter int LIM_SLOW = 400,
    parameter int LIM_FAST = 600,
    parameter int DLY_CYC  = 50,
    parameter int MAX_PH   = 4,
    parameter int VOUT_ARM = 50,
    parameter int DAC_ARM  = 60
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          supply_ok,
    input  logic [SW-1:0] sense_code,
    input  logic [2:0]    full_phases,
    input  logic [1:0]    pstate,
    input  logic [VW-1:0] vout_code,
    input  logic [VW-1:0] dac_code,
    output logic          fault_latched,
    output logic          drv_off
);
    localparam int NLVL = 2;
    localparam int LVL_SLOW = 0;
    localparam int LVL_FAST = 1;

    ocp_state_t st_d, st_q;
    logic       clr;
    logic       armed_q;
    logic       reduced;
    logic [NLVL-1:0] over;
    logic       run_slow;
    logic       slow_expire;

    assign clr     = !en || !supply_ok;
    assign reduced = pstate_e'(pstate) != PST_FULL;

    for (genvar lv = 0; lv < NLVL; lv++) begin : g_lvl
        localparam int LIM = (lv == LVL_SLOW) ? LIM_SLOW : LIM_FAST;
        ocp_lvl_cmp #(.SW(SW), .LIMIT(LIM), .MAX_PH(MAX_PH)) u_cmp (
            .sense   (sense_code),
            .nph_raw (full_phases),
            .reduced (reduced),
            .over    (over[lv])
        );
    end

    ocp_arm #(.VW(VW), .VOUT_ARM(VOUT_ARM), .DAC_ARM(DAC_ARM)) u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .vout    (vout_code),
        .dac     (dac_code),
        .armed_q (armed_q)
    );

    assign run_slow = !clr && armed_q && !st_q.fault && over[LVL_SLOW];

    ocp_delay_cnt #(.DLY(DLY_CYC)) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_slow),
        .expire (slow_expire)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.fault   = 1'b0;
            st_d.drv_off = 1'b1;
        end else begin
            st_d.fault   = st_q.fault || (armed_q && (over[LVL_FAST] || slow_expire));
            st_d.drv_off = st_d.fault;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= OCP_RESET;
        else        st_q <= st_d;
    end

    assign fault_latched = st_q.fault;
    assign drv_off       = st_q.drv_off;

endmodule

// File: rtl/ocp_fault_timer_chk.sv
module ocp_fault_timer_chk #(
    parameter int SW       = 10,
    parameter int LIM_FAST = 600
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          supply_ok,
    input logic [1:0]    pstate,
    input logic [SW-1:0] sense,
    input logic          armed,
    input logic          fault,
    input logic          drv_off
);
    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && en && supply_ok) |=> fault);

    assert_fault_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || !supply_ok) |=> (!fault && drv_off));

    assert_drv_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> drv_off);

    assert_fast_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && en && supply_ok && pstate == 2'd0 && sense > SW'(LIM_FAST)) |=> fault);

    assert_no_trip_unarmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !fault) |=> !fault);

endmodule

bind ocp_fault_timer ocp_fault_timer_chk #(.SW(SW), .LIM_FAST(LIM_FAST)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .supply_ok (supply_ok),
    .pstate    (pstate),
    .sense     (sense_code),
    .armed     (armed_q),
    .fault     (fault_latched),
    .drv_off   (drv_off)
);

// File: tb/tb_ocp_fault_timer.sv
`timescale 1ns/1ps
module tb_ocp_fault_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       supply_ok = 1'b1;
    logic [9:0] sense_code = '0;
    logic [2:0] full_phases = 3'd4;
    logic [1:0] pstate = 2'd0;
    logic [7:0] vout_code = '0;
    logic [7:0] dac_code = '0;
    logic       fault_latched;
    logic       drv_off;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ocp_fault_timer dut (
        .clk(clk), .rst_n(rst_n), .en(en), .supply_ok(supply_ok),
        .sense_code(sense_code), .full_phases(full_phases), .pstate(pstate),
        .vout_code(vout_code), .dac_code(dac_code),
        .fault_latched(fault_latched), .drv_off(drv_off)
    );

    // {pstate, phases, sense, hold edges, expected fault}
    localparam logic [23:0] VEC [0:11] = '{
        {2'd0, 3'd4, 10'd401, 8'd50, 1'b1},  // R1 slow trip
        {2'd0, 3'd4, 10'd401, 8'd49, 1'b0},  // R1 one short
        {2'd0, 3'd4, 10'd400, 8'd60, 1'b0},  // R1 at limit
        {2'd0, 3'd4, 10'd601, 8'd1,  1'b1},  // R3 fast
        {2'd1, 3'd3, 10'd133, 8'd60, 1'b0},  // R4 399 not over
        {2'd1, 3'd3, 10'd134, 8'd50, 1'b1},  // R4 402 over
        {2'd1, 3'd3, 10'd201, 8'd1,  1'b1},  // R4 fast scaled
        {2'd1, 3'd3, 10'd200, 8'd1,  1'b0},  // R4 fast at limit
        {2'd2, 3'd4, 10'd101, 8'd50, 1'b1},  // R4 four phases
        {2'd0, 3'd4, 10'd101, 8'd60, 1'b0},  // R4 full state unscaled
        {2'd3, 3'd2, 10'd301, 8'd1,  1'b1},  // R4 two phases fast
        {2'd3, 3'd0, 10'd401, 8'd50, 1'b1}   // R5 code 0 as one
    };

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic restart_armed();
        sense_code = '0;
        en = 1'b0; vout_code = '0; dac_code = '0;
        step(2);
        en = 1'b1; vout_code = 8'd60;
        step();
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual 0 expected 1 (run completion)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #5;
        chk("R9 fault in reset", int'(fault_latched), 0);
        chk("R9 drv_off in reset", int'(drv_off), 1);
        rst_n = 1'b1;
        step(2);
        chk("R9 fault after reset", int'(fault_latched), 0);
        chk("R8 drv_off disabled", int'(drv_off), 1);

        for (int i = 0; i < 12; i++) begin
            restart_armed();
            pstate = VEC[i][23:22];
            full_phases = VEC[i][21:19];
            sense_code = VEC[i][18:9];
            step(int'(VEC[i][8:1]));
            chk($sformatf("R1/R3/R4/R5 vector %0d fault", i), int'(fault_latched), int'(VEC[i][0]));
            chk($sformatf("R8 vector %0d drv_off", i), int'(drv_off), int'(VEC[i][0]));
        end

        // R2 dip restarts the count
        pstate = 2'd0; full_phases = 3'd4;
        restart_armed();
        sense_code = 10'd401; step(30);
        sense_code = 10'd100; step();
        sense_code = 10'd401; step(49);
        chk("R2 no trip 49 after dip", int'(fault_latched), 0);
        chk("R8 drv_off low while running", int'(drv_off), 0);
        step();
        chk("R2 trip 50 after dip", int'(fault_latched), 1);

        // R7 latch survives current drop
        sense_code = '0; step(10);
        chk("R7 fault held", int'(fault_latched), 1);
        chk("R8 drv_off held", int'(drv_off), 1);

        // R7 en low clears and disarms; R6 no trip unarmed
        en = 1'b0; step();
        chk("R7 cleared by en", int'(fault_latched), 0);
        chk("R8 drv_off while disabled", int'(drv_off), 1);
        en = 1'b1; vout_code = '0; dac_code = '0;
        sense_code = 10'd700; step(60);
        chk("R6 unarmed no trip", int'(fault_latched), 0);
        dac_code = 8'd61; step();
        chk("R6 arming edge no trip", int'(fault_latched), 0);
        step();
        chk("R6 trip after arming by dac", int'(fault_latched), 1);

        // R7 supply drop clears
        supply_ok = 1'b0; step();
        chk("R7 cleared by supply", int'(fault_latched), 0);
        chk("R8 drv_off on supply loss", int'(drv_off), 1);
        supply_ok = 1'b1; dac_code = '0; vout_code = 8'd50; step(3);
        chk("R6 vout at level does not arm", int'(fault_latched), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule